// File: doc/BRIEF.md
# Master-Mode Stereo Audio Timing Generator

This block is the clock master of a two-channel serial audio link. It runs from a master clock at 256 times the sample rate and derives every link timing signal from it: a bit clock, a left/right word clock and a frame strobe. The frame strobe rises once per channel slot and stays high only while that slot carries valid sample bits.

At the start of every left slot it captures a pair of 24-bit samples from its inputs. It then shifts the left word out, followed by the right word, MSB first and left-justified in each 32-bit slot. A one-cycle ready pulse tells the sample source that the pair has been taken, so the source can present the next pair.

An active-low power-down input stops the link. While it is low, every output is held low. When it is released, a new frame starts with a left slot on the next master-clock edge.

Top module: `audio_frame_master`

## Requirements
- R1: `bitClk` has a period of 4 master-clock cycles: 2 cycles low, then 2 cycles high.
- R2: `wordClk` has a period of 256 master-clock cycles (64 bit clocks). It is high for the 32 bit clocks of the left slot and low for the 32 bit clocks of the right slot. It rises only in a cycle where `sampleReady` is high.
- R3: `wordClk` and `frameStrobe` change only in the cycle where `bitClk` falls, except when they are forced low by power-down.
- R4: `frameStrobe` is high for the first 24 bit clocks of each 32-bit-clock slot and low for the last 8. This gives two pulses per word-clock period.
- R5: `serialData` carries the latched left word during the left slot and the latched right word during the right slot, MSB first. Bit n of a slot (n = 0..23) is sample bit 23-n. The data changes only where `bitClk` falls and is stable while `bitClk` is high.
- R6: `serialData` is low whenever `frameStrobe` is low.
- R7: `sampleReady` is high for exactly one master-clock cycle per frame, in the first cycle of the left slot. The inputs are captured at the clock edge that raises it. Changes to the inputs after that edge do not affect the frame in progress, including its right slot.
- R8: When `pwrDownN` is sampled low, all outputs are low from the next cycle on. When it is sampled high again, the next cycle shows the first cycle of a left slot, with `sampleReady` high.
- R9: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, 256 times the sample rate |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDownN | input | 1 | Active-low power-down; low stops the link and silences all outputs |
| leftIn | input | 24 | Left-channel sample, captured at the start of a frame |
| rightIn | input | 24 | Right-channel sample, captured with the left one |
| sampleReady | output | 1 | One-cycle pulse when a sample pair has been captured |
| bitClk | output | 1 | Bit clock, master clock divided by 4 |
| wordClk | output | 1 | Word clock, high during the left slot |
| frameStrobe | output | 1 | High while a slot carries valid data bits |
| serialData | output | 1 | Serial sample data, changing where the bit clock falls |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 32-bit slots and 4 master clocks per bit. With these values a full frame is 256 cycles, so every cycle of several frames can be compared against an independent model. That covers the 8-bit idle gap after each word, the switch between the left and right slots, and the alternating-bit and MSB/LSB-only patterns that expose shift errors. The bench also changes the inputs in the middle of a frame and during power-down. This checks that capture happens only at a frame start, and that release from power-down starts a left slot at once.

// File: rtl/afm_pkg.sv
package afm_pkg;

  // Strobes from the control section to the datapath, valid for one
  // master-clock cycle each.
  typedef struct packed {
    logic loadPair;   // capture both input words, left goes to the shifter
    logic loadRight;  // move the held right word into the shifter
    logic shiftBit;   // advance the shifter by one bit
  } afmStrobe_t;

endpackage

// File: rtl/afm_ctrl.sv
module afm_ctrl
  import afm_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int SLOT_BITS    = 32,
  parameter int MCLK_PER_BIT = 4
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       pwrDownN,
  output afmStrobe_t stb,
  output logic       bitClk,
  output logic       wordClk,
  output logic       frameStrobe,
  output logic       sampleReady
);

  localparam int PH_W = (MCLK_PER_BIT > 1) ? $clog2(MCLK_PER_BIT) : 1;
  localparam int BIT_W = $clog2(SLOT_BITS);
  localparam int HALF = MCLK_PER_BIT / 2;

  logic [PH_W-1:0]  phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             slotRight;

  logic phaseLast, bitLast, atBitStart, inData, highHalf;

  assign phaseLast  = (phaseCnt == PH_W'(MCLK_PER_BIT - 1));
  assign bitLast    = (bitCnt == BIT_W'(SLOT_BITS - 1));
  assign atBitStart = (phaseCnt == '0);
  assign inData     = ({1'b0, bitCnt} < (BIT_W + 1)'(SAMPLE_W));
  assign highHalf   = ({1'b0, phaseCnt} >= (PH_W + 1)'(HALF));

  // Position counters: phase within a bit, bit within a slot, slot select.
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      bitCnt    <= '0;
      slotRight <= 1'b0;
    end else if (!pwrDownN) begin
      phaseCnt  <= '0;
      bitCnt    <= '0;
      slotRight <= 1'b0;
    end else if (phaseLast) begin
      phaseCnt <= '0;
      if (bitLast) begin
        bitCnt    <= '0;
        slotRight <= ~slotRight;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // Datapath strobes, all at the start of a bit (where the bit clock falls).
  always_comb begin
    stb.loadPair  = pwrDownN && atBitStart && (bitCnt == '0) && !slotRight;
    stb.loadRight = pwrDownN && atBitStart && (bitCnt == '0) && slotRight;
    stb.shiftBit  = pwrDownN && atBitStart && (bitCnt != '0) && inData;
  end

  // Registered link outputs.
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      bitClk      <= 1'b0;
      wordClk     <= 1'b0;
      frameStrobe <= 1'b0;
      sampleReady <= 1'b0;
    end else begin
      bitClk      <= pwrDownN && highHalf;
      wordClk     <= pwrDownN && !slotRight;
      frameStrobe <= pwrDownN && inData;
      sampleReady <= stb.loadPair;
    end
  end

  assert_ready_single_R7: assert property (@(posedge mclk) disable iff (!rstN)
    sampleReady |=> !sampleReady);

  assert_word_rise_R2: assert property (@(posedge mclk) disable iff (!rstN)
    $rose(wordClk) |-> sampleReady);

  assert_word_fall_R3: assert property (@(posedge mclk) disable iff (!rstN)
    ($fell(wordClk) && $past(pwrDownN)) |-> $fell(bitClk));

  assert_strobe_fall_R4: assert property (@(posedge mclk) disable iff (!rstN)
    ($fell(frameStrobe) && $past(pwrDownN)) |-> $fell(bitClk));

endmodule

// File: rtl/afm_data.sv
module afm_data
  import afm_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                mclk,
  input  logic                rstN,
  input  logic                pwrDownN,
  input  afmStrobe_t          stb,
  input  logic                frameStrobe,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                serialData
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] holdRight;

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      holdRight <= '0;
    end else if (!pwrDownN) begin
      shiftReg <= '0;
    end else if (stb.loadPair) begin
      shiftReg  <= leftIn;
      holdRight <= rightIn;
    end else if (stb.loadRight) begin
      shiftReg <= holdRight;
    end else if (stb.shiftBit) begin
      shiftReg <= {shiftReg[SAMPLE_W-2:0], 1'b0};
    end
  end

  // Outside the valid window of a slot the line is driven low.
  assign serialData = frameStrobe & shiftReg[SAMPLE_W-1];

endmodule

// File: rtl/audio_frame_master.sv
module audio_frame_master
  import afm_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int SLOT_BITS    = 32,
  parameter int MCLK_PER_BIT = 4
) (
  input  logic                mclk,
  input  logic                rstN,
  input  logic                pwrDownN,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                sampleReady,
  output logic                bitClk,
  output logic                wordClk,
  output logic                frameStrobe,
  output logic                serialData
);

  afmStrobe_t stb;

  afm_ctrl #(
    .SAMPLE_W    (SAMPLE_W),
    .SLOT_BITS   (SLOT_BITS),
    .MCLK_PER_BIT(MCLK_PER_BIT)
  ) u_ctrl (
    .mclk       (mclk),
    .rstN       (rstN),
    .pwrDownN   (pwrDownN),
    .stb        (stb),
    .bitClk     (bitClk),
    .wordClk    (wordClk),
    .frameStrobe(frameStrobe),
    .sampleReady(sampleReady)
  );

  afm_data #(
    .SAMPLE_W(SAMPLE_W)
  ) u_data (
    .mclk       (mclk),
    .rstN       (rstN),
    .pwrDownN   (pwrDownN),
    .stb        (stb),
    .frameStrobe(frameStrobe),
    .leftIn     (leftIn),
    .rightIn    (rightIn),
    .serialData (serialData)
  );

  assert_data_hold_R5: assert property (@(posedge mclk) disable iff (!rstN)
    (bitClk && $past(bitClk)) |-> $stable(serialData));

  assert_pd_quiet_R8: assert property (@(posedge mclk) disable iff (!rstN)
    !pwrDownN |=> !(bitClk || wordClk || frameStrobe || serialData || sampleReady));

endmodule

// File: tb/audio_frame_master_tb.sv
module audio_frame_master_tb;

  localparam int SW   = 24;
  localparam int SLOT = 32;
  localparam int MPB  = 4;
  localparam int FRAME = 2 * SLOT * MPB;

  logic          mclk = 1'b0;
  logic          rstN;
  logic          pwrDownN;
  logic [SW-1:0] leftIn;
  logic [SW-1:0] rightIn;
  logic          sampleReady, bitClk, wordClk, frameStrobe, serialData;

  int total = 0;
  int bad   = 0;

  always #2.5 mclk = ~mclk;

  audio_frame_master u_dut (
    .mclk(mclk), .rstN(rstN), .pwrDownN(pwrDownN),
    .leftIn(leftIn), .rightIn(rightIn),
    .sampleReady(sampleReady), .bitClk(bitClk), .wordClk(wordClk),
    .frameStrobe(frameStrobe), .serialData(serialData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] outVec();
    return {sampleReady, bitClk, wordClk, frameStrobe, serialData};
  endfunction

  // Called at the negedge showing offset 0 of a frame (sampleReady cycle).
  // Checks the whole frame; sets the next inputs at offset changeAt.
  task automatic captureFrame(input logic [SW-1:0] expL, input logic [SW-1:0] expR,
                              input logic [SW-1:0] nxtL, input logic [SW-1:0] nxtR,
                              input int changeAt, input string name);
    int errs[7];
    int fk[7];
    int fa[7];
    int fe[7];
    logic pb = 1'b0, pw = 1'b0, ps = 1'b0;
    string tags[7] = '{"R1 bitClk", "R2 wordClk", "R4 frameStrobe", "R5 serialData",
                       "R6 idle data", "R7 sampleReady", "R3 edge alignment"};
    for (int i = 0; i < 7; i++) begin errs[i] = 0; fk[i] = 0; fa[i] = 0; fe[i] = 0; end
    for (int k = 0; k < FRAME; k++) begin
      int b;
      logic eb, ew, es, ed, er;
      logic [SW-1:0] smp;
      int got[7];
      int exp[7];
      if (k > 0) @(negedge mclk);
      b   = (k / MPB) % SLOT;
      eb  = (k % MPB) >= MPB / 2;
      ew  = k < FRAME / 2;
      es  = b < SW;
      smp = ew ? expL : expR;
      ed  = es ? smp[SW-1-b] : 1'b0;
      er  = (k == 0);
      got = '{int'(bitClk), int'(wordClk), int'(frameStrobe), int'(serialData),
              int'(serialData), int'(sampleReady), 0};
      exp = '{int'(eb), int'(ew), int'(es), int'(ed), int'(ed), int'(er), 0};
      if (k > 0 && (wordClk != pw || frameStrobe != ps) && !(pb && !bitClk)) begin
        got[6] = 1;
      end
      for (int i = 0; i < 7; i++) begin
        if (i == 3 && !es) continue;
        if (i == 4 && es) continue;
        if (got[i] != exp[i]) begin
          if (errs[i] == 0) begin fk[i] = k; fa[i] = got[i]; fe[i] = exp[i]; end
          errs[i]++;
        end
      end
      pb = bitClk; pw = wordClk; ps = frameStrobe;
      if (k == changeAt) begin leftIn = nxtL; rightIn = nxtR; end
    end
    for (int i = 0; i < 7; i++) begin
      if (errs[i] != 0)
        $display("  %s frame %s: first mismatch at offset %0d (%0d mismatches)",
                 tags[i], name, fk[i], errs[i]);
      check(errs[i] == 0, tags[i], name, fa[i], fe[i]);
    end
  endtask

  task automatic test_reset();
    rstN = 1'b0; pwrDownN = 1'b1;
    leftIn = 24'hA5C3F1; rightIn = 24'h5A3C0E;
    repeat (5) @(negedge mclk);
    check(outVec() == 5'b0, "R9", "outputs in reset", outVec(), 0);
    rstN = 1'b1;
    @(negedge mclk);
  endtask

  task automatic test_patterns();
    captureFrame(24'hA5C3F1, 24'h5A3C0E, 24'hFFFFFF, 24'h000000, 0, "first");
    @(negedge mclk);
    captureFrame(24'hFFFFFF, 24'h000000, 24'h800001, 24'h7FFFFE, 0, "ones-zeros");
    @(negedge mclk);
  endtask

  task automatic test_midchange();
    // R7: new words appear at offset 200, inside the right slot
    captureFrame(24'h800001, 24'h7FFFFE, 24'h123456, 24'h654321, 200, "midchange");
    @(negedge mclk);
    captureFrame(24'h123456, 24'h654321, 24'h123456, 24'h654321, 0, "after-change");
    @(negedge mclk);
  endtask

  task automatic test_powerdown();
    int loud = 0;
    repeat (40) @(negedge mclk);
    pwrDownN = 1'b0;
    @(negedge mclk);
    check(outVec() == 5'b0, "R8", "outputs after power-down", outVec(), 0);
    leftIn = 24'hABCDEF; rightIn = 24'hFEDCBA;
    repeat (30) begin
      @(negedge mclk);
      if (outVec() != 5'b0) loud++;
    end
    check(loud == 0, "R8", "cycles with activity in power-down", loud, 0);
    pwrDownN = 1'b1;
    @(negedge mclk);
    check(sampleReady && wordClk, "R8", "left slot start after release",
          {sampleReady, wordClk}, 3);
    captureFrame(24'hABCDEF, 24'hFEDCBA, 24'hABCDEF, 24'hFEDCBA, 0, "post-release");
  endtask

  initial begin
    repeat (150000) @(posedge mclk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_patterns();
    test_midchange();
    test_powerdown();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule